// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a leaf page table entry. It reads an in-memory radix page table of three levels, one entry at a time. Pages are 8 KiB. Each table level is indexed by 10 bits of the virtual page number, and each entry is 64 bits wide. The walk starts from a table base register. Software loads that register through a write strobe, and the block forces the written value to page alignment.

A request carries a 43-bit virtual address. The low 13 bits are the page offset and the walker does not use them. While the walk is in progress the block raises `busy` and issues reads on a single-outstanding memory request/response port. It classifies each returned entry as a leaf, a pointer to a next-level table, or invalid.

A leaf can be found above the last level. In that case the walker adds the low virtual page number bits below that level to the entry's page number, so the result always names the exact 8 KiB page. The walk ends with a one-cycle `done` pulse together with either a fault flag or the resolved entry and its physical page number.

Top module: `radix_walker`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mem_req_valid` are low until a request is accepted.
- R2: A base write stores `base_din` with bits 12..0 cleared. Each later walk starts from that stored base.
- R3: A walk starts at level 2. The entry address at level i is the table base plus 8 times `req_vaddr[13+10i +: 10]`, so each entry address is a multiple of 8.
- R4: A returned entry with bit 1 (leaf) set ends the walk without a fault. `res_pte` is the entry with its page number field, bits 63..13, replaced by `res_ppn`. This holds even when bit 0 is also set.
- R5: An entry with bit 0 (table) set and bit 1 clear, read at level 1 or 2, makes bits 63..13 of the entry, shifted left by 13, the base for the next lower level.
- R6: A leaf read at level i has `res_ppn` equal to the entry's bits 63..13 plus the low 10·i bits of the virtual page number, taken modulo 2^51. This is an arithmetic sum, not a bitwise OR.
- R7: An entry with both bit 0 and bit 1 clear ends the walk with `fault` high. On a fault, `res_pte` and `res_ppn` are zero.
- R8: An entry at level 0 with bit 0 set and bit 1 clear ends the walk with a fault.
- R9: An entry address at or above `MEM_LIMIT` ends the walk with a fault, and no memory read is issued for it.
- R10: Only one walk runs at a time. `busy` is high from the cycle after a request is accepted until `done`. A `req_valid` seen while `busy` is high is ignored.
- R11: `done` is high for exactly one cycle per walk. Each `mem_req_valid` is a single-cycle pulse, and the next one comes only after `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Write strobe for the table base register |
| base_din | input | 64 | Table base value; the low 13 bits are dropped |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_vaddr | input | 43 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Entry read request, one cycle |
| mem_req_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Returned page table entry |
| done | output | 1 | Walk finished, one-cycle pulse |
| fault | output | 1 | Walk ended without a leaf (valid with done) |
| res_pte | output | 64 | Leaf entry with adjusted page number |
| res_ppn | output | 51 | Resolved physical page number |

## Verification
The bench targets superpage leaves at levels 2 and 1, using page numbers whose low bits are not zero. A walker that ORs the offset instead of adding it, or that takes the wrong number of low bits, would return the wrong page number. It drives an entry with both flag bits set, which a design testing the table bit first would walk past. It also drives a table pointer at level 0, which a walker without a level floor would follow into a fourth read. It runs entry addresses past the memory limit, both at the first level and after a pointer. A design that skipped the range check would issue an out-of-range read, and the bench reports that as an unexpected address. Finally, it writes an unaligned base and raises a second request in the middle of a walk. A design that kept the low base bits, or that restarted on the second request, would produce read addresses that differ from the model's queue.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int unsigned PG_SHIFT  = 13;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned LEVELS    = 3;
  localparam int unsigned PTE_W     = 64;
  localparam int unsigned PA_W      = 64;
  localparam int unsigned VA_W      = PG_SHIFT + IDX_W * LEVELS;
  localparam int unsigned VPN_W     = VA_W - PG_SHIFT;
  localparam int unsigned PPN_W     = PTE_W - PG_SHIFT;
  localparam int unsigned LVL_W     = $clog2(LEVELS);
  localparam int unsigned ENT_SHIFT = $clog2(PTE_W / 8);
  localparam int unsigned TBL_BIT   = 0;
  localparam int unsigned LEAF_BIT  = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/walk_rst_sync.sv
module walk_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
  import walk_pkg::*;
#(
  parameter logic [PA_W-1:0] MEM_LIMIT = 64'h0000_0000_0001_0000
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  ent_addr,
  output logic             beyond_mem
);
  logic [IDX_W-1:0] idx_at [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  // one index slice per table level
  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
      assign idx_at[g] = vpn[g*IDX_W +: IDX_W];
    end
  endgenerate

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx_sel = idx_at[i];
    end
  end

  assign ent_addr   = tbl_base + (PA_W'(idx_sel) << ENT_SHIFT);
  assign beyond_mem = (ent_addr >= MEM_LIMIT);
endmodule

// File: rtl/walk_pte_eval.sv
module walk_pte_eval
  import walk_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic             is_leaf,
  output logic             is_table,
  output logic [PA_W-1:0]  next_base,
  output logic [PTE_W-1:0] leaf_pte,
  output logic [PPN_W-1:0] leaf_ppn
);
  logic [PPN_W-1:0] off_at [LEVELS];
  logic [PPN_W-1:0] off_sel;
  logic             unused_vpn_hi;

  // page-granular offset inside a superpage found at level g
  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_off
      if (g == 0) begin : g_base
        assign off_at[g] = '0;
      end else begin : g_super
        assign off_at[g] = PPN_W'(vpn[g*IDX_W-1:0]);
      end
    end
  endgenerate

  always_comb begin
    off_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) off_sel = off_at[i];
    end
  end

  assign unused_vpn_hi = ^vpn[VPN_W-1:(LEVELS-1)*IDX_W];

  assign is_leaf   = pte[LEAF_BIT];
  assign is_table  = pte[TBL_BIT];
  assign next_base = PA_W'({pte[PTE_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}});
  assign leaf_ppn  = pte[PTE_W-1:PG_SHIFT] + off_sel;
  assign leaf_pte  = {leaf_ppn, pte[PG_SHIFT-1:0]};
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import walk_pkg::*;
#(
  parameter logic [PA_W-1:0] MEM_LIMIT = 64'h0000_0000_0001_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_wr,
  input  logic [PA_W-1:0]  base_din,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [PTE_W-1:0] res_pte,
  output logic [PPN_W-1:0] res_ppn
);
  logic rst_sn;

  walk_state_e      state_q, state_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [PA_W-1:0]  base_q,  base_d;
  logic [PA_W-1:0]  ptbr_q,  ptbr_d;
  logic [VPN_W-1:0] vpn_q;
  logic             done_q,  done_d;
  logic             fault_q, fault_d;
  logic [PTE_W-1:0] res_pte_q, res_pte_d;
  logic [PPN_W-1:0] res_ppn_q, res_ppn_d;
  logic             ptbr_en, walk_en, start_en, res_en;

  logic [PA_W-1:0]  ent_addr;
  logic             beyond_mem;
  logic             is_leaf, is_table;
  logic [PA_W-1:0]  next_base;
  logic [PTE_W-1:0] leaf_pte;
  logic [PPN_W-1:0] leaf_ppn;
  logic             unused_lo;

  assign unused_lo = ^{req_vaddr[PG_SHIFT-1:0], base_din[PG_SHIFT-1:0]};

  walk_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  walk_addr_gen #(
    .MEM_LIMIT (MEM_LIMIT)
  ) u_addr_gen (
    .tbl_base   (base_q),
    .vpn        (vpn_q),
    .level      (level_q),
    .ent_addr   (ent_addr),
    .beyond_mem (beyond_mem)
  );

  walk_pte_eval u_pte_eval (
    .pte       (mem_rsp_data),
    .vpn       (vpn_q),
    .level     (level_q),
    .is_leaf   (is_leaf),
    .is_table  (is_table),
    .next_base (next_base),
    .leaf_pte  (leaf_pte),
    .leaf_ppn  (leaf_ppn)
  );

  // base register: page-aligned on every write
  always_comb begin
    ptbr_en = base_wr;
    ptbr_d  = {base_din[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  end

  // walk sequencing
  always_comb begin
    state_d   = state_q;
    level_d   = level_q;
    base_d    = base_q;
    walk_en   = 1'b0;
    start_en  = 1'b0;
    done_d    = 1'b0;
    fault_d   = 1'b0;
    res_en    = 1'b0;
    res_pte_d = '0;
    res_ppn_d = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          start_en = 1'b1;
          walk_en  = 1'b1;
          level_d  = LVL_W'(LEVELS - 1);
          base_d   = ptbr_q;
          state_d  = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (beyond_mem) begin
          done_d  = 1'b1;
          fault_d = 1'b1;
          res_en  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (is_leaf) begin
            done_d    = 1'b1;
            res_en    = 1'b1;
            res_pte_d = leaf_pte;
            res_ppn_d = leaf_ppn;
            state_d   = ST_IDLE;
          end else if (is_table && (level_q != '0)) begin
            walk_en = 1'b1;
            level_d = level_q - 1'b1;
            base_d  = next_base;
            state_d = ST_ISSUE;
          end else begin
            done_d  = 1'b1;
            fault_d = 1'b1;
            res_en  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q   <= ST_IDLE;
      level_q   <= '0;
      base_q    <= '0;
      ptbr_q    <= '0;
      vpn_q     <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      res_pte_q <= '0;
      res_ppn_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      if (ptbr_en) ptbr_q <= ptbr_d;
      if (walk_en) begin
        level_q <= level_d;
        base_q  <= base_d;
      end
      if (start_en) vpn_q <= req_vaddr[VA_W-1:PG_SHIFT];
      if (res_en) begin
        res_pte_q <= res_pte_d;
        res_ppn_q <= res_ppn_d;
      end
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE) && !beyond_mem;
  assign mem_req_addr  = ent_addr;
  assign done          = done_q;
  assign fault         = fault_q;
  assign res_pte       = res_pte_q;
  assign res_ppn       = res_ppn_q;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk
  import walk_pkg::*;
#(
  parameter logic [PA_W-1:0] MEM_LIMIT = 64'h0000_0000_0001_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             mem_req_valid,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             done,
  input logic             fault,
  input logic [PPN_W-1:0] res_ppn
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R9
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr < MEM_LIMIT));

  // R3
  entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ENT_SHIFT-1:0] == '0));

  // R10
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R10
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R11
  rsp_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> busy);

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (res_ppn == '0));
endmodule

bind radix_walker radix_walker_chk #(
  .MEM_LIMIT (MEM_LIMIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault),
  .res_ppn       (res_ppn)
);

// File: tb/radix_walker_tb.sv
`timescale 1ns/1ps
module radix_walker_tb;
  localparam logic [63:0] MEM_LIM = 64'h1_0000;

  logic        clk;
  logic        rst_n;
  logic        base_wr;
  logic [63:0] base_din;
  logic        req_valid;
  logic [42:0] req_vaddr;
  logic        busy;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic        fault;
  logic [63:0] res_pte;
  logic [50:0] res_ppn;

  int n_vec;
  int n_bad;

  logic [63:0] mem_m [logic [63:0]];
  logic [63:0] exp_q [$];
  logic [63:0] ptbr_m;

  bit          pend;
  int          wait_cnt;
  int          lat_sel;
  logic [63:0] rd_word;

  radix_walker #(.MEM_LIMIT(MEM_LIM)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_wr       (base_wr),
    .base_din      (base_din),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .fault         (fault),
    .res_pte       (res_pte),
    .res_ppn       (res_ppn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkva(input int i2, input int i1, input int i0, input int ofs);
    return (64'(i2) << 33) | (64'(i1) << 23) | (64'(i0) << 13) | 64'(ofs);
  endfunction

  // behavioural walk: fills the expected read-address queue
  task automatic model(input logic [63:0] va, output bit f,
                       output logic [63:0] pte, output logic [63:0] ppn);
    logic [63:0] base;
    logic [63:0] a;
    logic [63:0] e;
    logic [63:0] vpn;
    bit          fin;
    base = ptbr_m;
    vpn  = va >> 13;
    fin  = 0;
    f    = 1;
    pte  = 0;
    ppn  = 0;
    for (int lv = 2; lv >= 0; lv--) begin
      if (!fin) begin
        a = base + ((va >> (13 + lv * 10)) & 64'h3FF) * 8;
        if (a >= MEM_LIM) begin
          fin = 1;
        end else begin
          exp_q.push_back(a);
          e = mem_m.exists(a) ? mem_m[a] : 64'h0;
          if (e[1]) begin
            ppn = ((e >> 13) + (vpn & ((64'd1 << (lv * 10)) - 1))) & ((64'd1 << 51) - 1);
            pte = (ppn << 13) | (e & 64'h1FFF);
            f   = 0;
            fin = 1;
          end else if (!e[0]) begin
            fin = 1;
          end else begin
            base = (e >> 13) << 13;
          end
        end
      end
    end
  endtask

  // memory responder and per-clock read-address comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      pend          = 0;
    end else begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (wait_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd_word;
          pend          = 0;
        end else begin
          wait_cnt--;
        end
      end
      if (mem_req_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected read", mem_req_addr, 64'h0);
        end else begin
          chk(mem_req_addr == exp_q[0], "R3", "read address", mem_req_addr, exp_q[0]);
          void'(exp_q.pop_front());
        end
        rd_word  = mem_m.exists(mem_req_addr) ? mem_m[mem_req_addr] : 64'h0;
        pend     = 1;
        wait_cnt = lat_sel % 3;
        lat_sel++;
      end
    end
  end

  task automatic set_base(input logic [63:0] v);
    @(negedge clk);
    base_wr  = 1'b1;
    base_din = v;
    @(negedge clk);
    base_wr  = 1'b0;
    ptbr_m   = v & ~64'h1FFF;
  endtask

  task automatic walk(input logic [63:0] va, input string req, input bit poke);
    bit          ef;
    logic [63:0] ep;
    logic [63:0] en;
    int          n;
    model(va, ef, ep, en);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va[42:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", 64'(busy), 64'h1);
    if (poke) begin
      req_valid = 1'b1;
      req_vaddr = ~va[42:0];
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R11", "done seen", 64'(done), 64'h1);
    chk(fault == ef, req, "fault flag", 64'(fault), 64'(ef));
    chk(res_pte == ep, req, "result entry", res_pte, ep);
    chk(64'(res_ppn) == en, req, "result page number", 64'(res_ppn), en);
    chk(busy == 1'b0, "R10", "idle at done", 64'(busy), 64'h0);
    chk(exp_q.size() == 0, "R3", "reads outstanding", 64'(exp_q.size()), 64'h0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", 64'(done), 64'h0);
    if (poke) begin
      repeat (8) @(negedge clk);
      chk(!done && !busy, "R10", "request during walk ignored", 64'({done, busy}), 64'h0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual %h expected %h", 64'h0, 64'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec     = 0;
    n_bad     = 0;
    lat_sel   = 0;
    ptbr_m    = 0;
    rst_n     = 1'b0;
    base_wr   = 1'b0;
    base_din  = '0;
    req_valid = 1'b0;
    req_vaddr = '0;

    // tables: level 2 at 0x2000, level 1 at 0x4000, level 0 at 0x6000
    mem_m[64'h2000 + 5*8]  = 64'h4001;
    mem_m[64'h4000 + 7*8]  = 64'h6001;
    mem_m[64'h6000 + 9*8]  = (64'h1234 << 13) | 64'h3F6;
    mem_m[64'h2000 + 6*8]  = (64'h80000 << 13) | 64'h6;
    mem_m[64'h4000 + 8*8]  = (64'h701 << 13) | 64'h2;
    mem_m[64'h6000 + 11*8] = 64'h1;
    mem_m[64'h6000 + 12*8] = (64'h55 << 13) | 64'h3;
    mem_m[64'h2000 + 7*8]  = 64'h20001;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req_valid, "R1", "outputs in reset",
        64'({busy, done, mem_req_valid}), 64'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !done && !mem_req_valid, "R1", "outputs after reset",
        64'({busy, done, mem_req_valid}), 64'h0);

    // R2: unaligned write lands on 0x2000
    set_base(64'h2ABC);
    walk(mkva(5, 7, 9, 16'h123), "R5", 0);       // three-level walk to a leaf
    walk(mkva(6, 16'h155, 16'h2AA, 0), "R6", 0); // level-2 superpage
    walk(mkva(5, 8, 16'h3FF, 4), "R6", 0);       // level-1 superpage with carry
    walk(mkva(5, 10, 0, 0), "R7", 0);            // invalid entry at level 1
    walk(mkva(5, 7, 11, 0), "R8", 0);            // table bit at level 0
    walk(mkva(5, 7, 12, 0), "R4", 0);            // both flag bits set
    walk(mkva(7, 0, 0, 0), "R9", 0);             // pointer beyond memory
    walk(mkva(5, 7, 9, 0), "R10", 1);            // second request while busy
    walk(mkva(1, 1, 1, 0), "R7", 0);             // empty top-level entry

    // R9: base itself beyond memory, no read at all
    set_base(64'h1_0FFF);
    walk(mkva(0, 0, 0, 0), "R9", 0);
    set_base(64'h2000);
    walk(mkva(6, 3, 4, 0), "R2", 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule